// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Address Filter

This block receives asynchronous serial frames of eight or nine data bits, least significant bit first, and decides at the end of each frame whether to keep it. A frame that is kept loads the 8-bit receive buffer and the ninth-bit register, and sets the receive flag. A frame that is refused leaves the buffer, the ninth-bit register and the flag unchanged. Timing comes from an external tick that runs at sixteen times the bit rate. The serial line passes through a two-stage synchronizer before start-edge detection.

The filter enable supports multi-drop buses. In nine-bit mode a ninth bit of 1 marks an address frame and a ninth bit of 0 marks a data frame. With the filter on, data frames are refused. An address frame is kept only if its byte matches this node's masked own address or the broadcast address. Software turns the filter off once it has been addressed, so that the data frames that follow are kept. In eight-bit mode the filter enable only requires a valid stop bit. The receive flag stays set until software pulses the clear input. While the flag is set, every completed frame is dropped.

Top module: `mpuart_rx`

## Requirements
- R1: After reset the receive flag, the framing-error flag, the receive buffer and the ninth-bit register are all 0.
- R2: In eight-bit mode (`nineBitMode`=0) with the filter off, a completed frame loads its eight data bits into `rxData` and its stop-bit value into `rxBit9`, and sets `rxFlag`.
- R3: In nine-bit mode (`nineBitMode`=1) with the filter off, a completed frame loads data bits 0..7 into `rxData` and the ninth bit into `rxBit9`, and sets `rxFlag`, whatever the value of the ninth bit.
- R4: `rxFlag` stays at 1 until a one-cycle `clearRxFlag` pulse clears it. While `rxFlag` is 1, completed frames change neither `rxData` nor `rxBit9`.
- R5: In nine-bit mode with `addrFilterEn`=1, a frame whose ninth bit is 0 is dropped.
- R6: In nine-bit mode with `addrFilterEn`=1, an address frame (ninth bit 1) is kept when `(byte & addrMask) == (slaveAddr & addrMask)`.
- R7: In nine-bit mode with `addrFilterEn`=1, an address frame is kept when the byte has a 1 in every position where `slaveAddr | addrMask` has a 1 (broadcast match).
- R8: In nine-bit mode with `addrFilterEn`=1, an address frame that matches neither the own address nor the broadcast address is dropped.
- R9: In eight-bit mode with `addrFilterEn`=1, a frame whose stop bit samples as 0 is dropped. With the filter off, the same frame is kept and `rxBit9` is 0.
- R10: `frameErr` is set whenever a stop bit samples as 0, whether or not the frame is kept. Only a `clearFrameErr` pulse clears it.
- R11: If the line goes low and is high again at mid start bit (tick 8 after the falling edge), the receiver returns to idle and produces no frame. A normal frame that follows is still received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Asynchronous serial input, idle high |
| sampleTick | input | 1 | One-cycle pulse at 16x the bit rate |
| nineBitMode | input | 1 | 0: eight data bits; 1: nine data bits |
| addrFilterEn | input | 1 | Enables the acceptance filter |
| slaveAddr | input | 8 | Own node address |
| addrMask | input | 8 | Address mask; a 0 bit is don't-care in the own-address compare |
| clearRxFlag | input | 1 | Pulse that clears the receive flag |
| clearFrameErr | input | 1 | Pulse that clears the framing-error flag |
| rxData | output | 8 | Receive buffer |
| rxBit9 | output | 1 | Ninth bit (stop bit in eight-bit mode) of the last kept frame |
| rxFlag | output | 1 | A kept frame is waiting |
| frameErr | output | 1 | A stop bit sampled as 0 |

## Verification
The assertions assume that the mode, filter enable, address and mask inputs stay stable while a frame is in progress. They are checked against the values these inputs held in the cycle before the flag rose. The bench changes these inputs only between frames, after the line has been idle for a full bit time. It drives every frame at exactly sixteen ticks per bit, so each sample falls near mid-bit. It issues its clear pulses only while the line is idle.

// File: rtl/mpuart_rx_pkg.sv
package mpuart_rx_pkg;
  typedef struct packed {
    logic shiftEn;   // capture one data bit
    logic frameEnd;  // stop bit sampled, decide acceptance
    logic bitVal;    // synchronized line value at the sample point
  } rxStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rxState_t;
endpackage

// File: rtl/mpuart_rx_ctrl.sv
module mpuart_rx_ctrl
  import mpuart_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxLine,
  input  logic       sampleTick,
  input  logic       nineBitMode,
  output rxStrobe_t  strobes
);
  localparam int TICK_W = $clog2(OSR);
  localparam int BIT_W  = $clog2(DATA_W + 2);
  localparam logic [TICK_W-1:0] HALF_LAST = TICK_W'(OSR / 2 - 1);
  localparam logic [TICK_W-1:0] FULL_LAST = TICK_W'(OSR - 1);

  logic [2:0]        syncQ;
  logic              lineNow, linePrev;
  rxState_t          state;
  logic [TICK_W-1:0] tickCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [BIT_W-1:0]  lastBit;
  logic              fullBit;

  assign lineNow  = syncQ[1];
  assign linePrev = syncQ[2];
  assign lastBit  = nineBitMode ? BIT_W'(DATA_W) : BIT_W'(DATA_W - 1);
  assign fullBit  = sampleTick && (tickCnt == FULL_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[1:0], rxLine};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (linePrev && !lineNow) begin
            state   <= ST_START;
            tickCnt <= '0;
          end
        end
        ST_START: begin
          if (sampleTick) begin
            if (tickCnt == HALF_LAST) begin
              tickCnt <= '0;
              bitCnt  <= '0;
              state   <= lineNow ? ST_IDLE : ST_DATA;
            end else begin
              tickCnt <= tickCnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (sampleTick) begin
            tickCnt <= tickCnt + 1'b1;
            if (fullBit) begin
              tickCnt <= '0;
              bitCnt  <= bitCnt + 1'b1;
              if (bitCnt == lastBit) state <= ST_STOP;
            end
          end
        end
        default: begin
          if (sampleTick) begin
            tickCnt <= tickCnt + 1'b1;
            if (fullBit) begin
              tickCnt <= '0;
              state   <= ST_IDLE;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    strobes.shiftEn  = (state == ST_DATA) && fullBit;
    strobes.frameEnd = (state == ST_STOP) && fullBit;
    strobes.bitVal   = lineNow;
  end
endmodule

// File: rtl/mpuart_rx_dp.sv
module mpuart_rx_dp
  import mpuart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobes,
  input  logic              nineBitMode,
  input  logic              addrFilterEn,
  input  logic [DATA_W-1:0] slaveAddr,
  input  logic [DATA_W-1:0] addrMask,
  input  logic              clearRxFlag,
  input  logic              clearFrameErr,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxFlag,
  output logic              frameErr
);
  logic [DATA_W:0]   shiftReg;
  logic [DATA_W-1:0] frameByte;
  logic              frameNinth;
  logic [DATA_W-1:0] ownPattern, bcastPattern;
  logic              ownHit, bcastHit, passFilter, accept;

  always_comb begin
    if (nineBitMode) begin
      frameByte  = shiftReg[DATA_W-1:0];
      frameNinth = shiftReg[DATA_W];
    end else begin
      frameByte  = shiftReg[DATA_W:1];
      frameNinth = strobes.bitVal;
    end
    ownPattern   = slaveAddr & addrMask;
    bcastPattern = slaveAddr | addrMask;
    ownHit       = ((frameByte & addrMask) == ownPattern);
    bcastHit     = ((frameByte & bcastPattern) == bcastPattern);
    if (!addrFilterEn)    passFilter = 1'b1;
    else if (nineBitMode) passFilter = frameNinth && (ownHit || bcastHit);
    else                  passFilter = strobes.bitVal;
    accept = strobes.frameEnd && !rxFlag && passFilter;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {strobes.bitVal, shiftReg[DATA_W:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= '0;
      rxBit9   <= 1'b0;
      rxFlag   <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (clearRxFlag) rxFlag <= 1'b0;
      if (accept) begin
        rxData <= frameByte;
        rxBit9 <= frameNinth;
        rxFlag <= 1'b1;
      end
      if (clearFrameErr) frameErr <= 1'b0;
      if (strobes.frameEnd && !strobes.bitVal) frameErr <= 1'b1;
    end
  end
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
  import mpuart_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxLine,
  input  logic              sampleTick,
  input  logic              nineBitMode,
  input  logic              addrFilterEn,
  input  logic [DATA_W-1:0] slaveAddr,
  input  logic [DATA_W-1:0] addrMask,
  input  logic              clearRxFlag,
  input  logic              clearFrameErr,
  output logic [DATA_W-1:0] rxData,
  output logic              rxBit9,
  output logic              rxFlag,
  output logic              frameErr
);
  rxStrobe_t strobes;

  mpuart_rx_ctrl #(.OSR(OSR), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .sampleTick(sampleTick),
    .nineBitMode(nineBitMode), .strobes(strobes)
  );

  mpuart_rx_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .nineBitMode(nineBitMode),
    .addrFilterEn(addrFilterEn), .slaveAddr(slaveAddr), .addrMask(addrMask),
    .clearRxFlag(clearRxFlag), .clearFrameErr(clearFrameErr),
    .rxData(rxData), .rxBit9(rxBit9), .rxFlag(rxFlag), .frameErr(frameErr)
  );
endmodule

// File: rtl/mpuart_rx_chk.sv
module mpuart_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              nineBitMode,
  input logic              addrFilterEn,
  input logic [DATA_W-1:0] slaveAddr,
  input logic [DATA_W-1:0] addrMask,
  input logic              clearRxFlag,
  input logic              clearFrameErr,
  input logic [DATA_W-1:0] rxData,
  input logic              rxBit9,
  input logic              rxFlag,
  input logic              frameErr
);
  // R4: buffer and ninth bit change only together with a rising flag
  a_r4_buffer_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(rxData) || !$stable(rxBit9)) |-> $rose(rxFlag));

  // R4: flag holds without a clear pulse
  a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlag && !clearRxFlag) |=> rxFlag);

  // R4: flag falls only after a clear pulse
  a_r4_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rxFlag) |-> $past(clearRxFlag));

  // R10: framing error falls only after its clear pulse
  a_r10_ferr_clear: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameErr) |-> $past(clearFrameErr));

  // R5: with the filter on in nine-bit mode only address frames are kept
  a_r5_addr_only: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxFlag) && $past(nineBitMode) && $past(addrFilterEn)) |-> rxBit9);

  // R6 R7: a kept address frame matches own or broadcast pattern
  a_r6_addr_match: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxFlag) && $past(nineBitMode) && $past(addrFilterEn)) |->
      (((rxData ^ $past(slaveAddr)) & $past(addrMask)) == '0 ||
       ((~rxData) & ($past(slaveAddr) | $past(addrMask))) == '0));

  // R9: with the filter on in eight-bit mode a kept frame had a valid stop bit
  a_r9_stop_valid: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(rxFlag) && !$past(nineBitMode) && $past(addrFilterEn)) |-> rxBit9);
endmodule

bind mpuart_rx mpuart_rx_chk #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .nineBitMode(nineBitMode), .addrFilterEn(addrFilterEn),
  .slaveAddr(slaveAddr), .addrMask(addrMask), .clearRxFlag(clearRxFlag),
  .clearFrameErr(clearFrameErr), .rxData(rxData), .rxBit9(rxBit9),
  .rxFlag(rxFlag), .frameErr(frameErr)
);

// File: tb/mpuart_rx_test.sv
`timescale 1ns/1ps
module mpuart_rx_test;
  localparam int BIT_CLKS = 64; // 16 ticks x 4 clocks

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       sampleTick = 1'b0;
  logic       nineBitMode = 1'b0;
  logic       addrFilterEn = 1'b0;
  logic [7:0] slaveAddr = 8'h52;
  logic [7:0] addrMask = 8'hF0;
  logic       clearRxFlag = 1'b0;
  logic       clearFrameErr = 1'b0;
  logic [7:0] rxData;
  logic       rxBit9, rxFlag, frameErr;

  int  vectors = 0;
  int  errors = 0;
  bit  finished = 1'b0;
  logic [1:0] tickDiv = 2'd0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    tickDiv    <= tickDiv + 2'd1;
    sampleTick <= (tickDiv == 2'd3);
  end

  mpuart_rx uut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .sampleTick(sampleTick),
    .nineBitMode(nineBitMode), .addrFilterEn(addrFilterEn),
    .slaveAddr(slaveAddr), .addrMask(addrMask), .clearRxFlag(clearRxFlag),
    .clearFrameErr(clearFrameErr), .rxData(rxData), .rxBit9(rxBit9),
    .rxFlag(rxFlag), .frameErr(frameErr)
  );

  task automatic check(string req, string what, int actual, int expected);
    vectors++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, actual, expected);
    end
  endtask

  task automatic sendBit(logic b);
    @(negedge clk) rxLine = b;
    repeat (BIT_CLKS - 1) @(negedge clk);
  endtask

  task automatic sendFrame(logic [7:0] dataByte, logic ninth, logic useNinth, logic stopBit);
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(dataByte[i]);
    if (useNinth) sendBit(ninth);
    sendBit(stopBit);
    sendBit(1'b1);
    sendBit(1'b1);
  endtask

  task automatic pulseClearFlag();
    @(negedge clk) clearRxFlag = 1'b1;
    @(negedge clk) clearRxFlag = 1'b0;
  endtask

  task automatic pulseClearErr();
    @(negedge clk) clearFrameErr = 1'b1;
    @(negedge clk) clearFrameErr = 1'b0;
  endtask

  task automatic tReset();
    check("R1", "rxFlag", rxFlag, 0);
    check("R1", "frameErr", frameErr, 0);
    check("R1", "rxData", rxData, 0);
    check("R1", "rxBit9", rxBit9, 0);
  endtask

  task automatic tEightBit();
    nineBitMode = 1'b0; addrFilterEn = 1'b0;
    sendFrame(8'hA5, 1'b0, 1'b0, 1'b1);
    check("R2", "rxData", rxData, 8'hA5);
    check("R2", "rxBit9", rxBit9, 1);
    check("R2", "rxFlag", rxFlag, 1);
    check("R10", "frameErr", frameErr, 0);
    pulseClearFlag();
    @(negedge clk);
    check("R4", "rxFlag after clear", rxFlag, 0);
  endtask

  task automatic tNineBitAndHold();
    nineBitMode = 1'b1; addrFilterEn = 1'b0;
    sendFrame(8'h3C, 1'b0, 1'b1, 1'b1);
    check("R3", "rxData", rxData, 8'h3C);
    check("R3", "rxBit9", rxBit9, 0);
    check("R3", "rxFlag", rxFlag, 1);
    sendFrame(8'h11, 1'b1, 1'b1, 1'b1);
    check("R4", "rxData kept", rxData, 8'h3C);
    check("R4", "rxBit9 kept", rxBit9, 0);
    check("R4", "rxFlag still set", rxFlag, 1);
    pulseClearFlag();
  endtask

  task automatic tFilterData();
    nineBitMode = 1'b1; addrFilterEn = 1'b1;
    sendFrame(8'h57, 1'b0, 1'b1, 1'b1);
    check("R5", "rxFlag", rxFlag, 0);
    check("R5", "rxData kept", rxData, 8'h3C);
  endtask

  task automatic tOwnAddr();
    sendFrame(8'h57, 1'b1, 1'b1, 1'b1);
    check("R6", "rxFlag", rxFlag, 1);
    check("R6", "rxData", rxData, 8'h57);
    check("R6", "rxBit9", rxBit9, 1);
    pulseClearFlag();
  endtask

  task automatic tBroadcast();
    sendFrame(8'hF2, 1'b1, 1'b1, 1'b1);
    check("R7", "rxFlag", rxFlag, 1);
    check("R7", "rxData", rxData, 8'hF2);
    pulseClearFlag();
  endtask

  task automatic tNoMatch();
    sendFrame(8'h63, 1'b1, 1'b1, 1'b1);
    check("R8", "rxFlag", rxFlag, 0);
    check("R8", "rxData kept", rxData, 8'hF2);
  endtask

  task automatic tStopBit();
    nineBitMode = 1'b0; addrFilterEn = 1'b1;
    sendFrame(8'h0F, 1'b0, 1'b0, 1'b0);
    check("R9", "rxFlag filtered", rxFlag, 0);
    check("R9", "rxData kept", rxData, 8'hF2);
    check("R10", "frameErr set on drop", frameErr, 1);
    pulseClearErr();
    @(negedge clk);
    check("R10", "frameErr cleared", frameErr, 0);
    addrFilterEn = 1'b0;
    sendFrame(8'h81, 1'b0, 1'b0, 1'b0);
    check("R9", "rxFlag unfiltered", rxFlag, 1);
    check("R9", "rxData", rxData, 8'h81);
    check("R9", "rxBit9", rxBit9, 0);
    check("R10", "frameErr set on keep", frameErr, 1);
    pulseClearFlag();
    pulseClearErr();
  endtask

  task automatic tGlitch();
    nineBitMode = 1'b0; addrFilterEn = 1'b0;
    @(negedge clk) rxLine = 1'b0;
    repeat (16) @(negedge clk);
    rxLine = 1'b1;
    repeat (12 * BIT_CLKS) @(negedge clk);
    check("R11", "rxFlag after glitch", rxFlag, 0);
    check("R11", "rxData after glitch", rxData, 8'h81);
    check("R11", "frameErr after glitch", frameErr, 0);
    sendFrame(8'h42, 1'b0, 1'b0, 1'b1);
    check("R11", "rxData next frame", rxData, 8'h42);
    check("R11", "rxFlag next frame", rxFlag, 1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (BIT_CLKS) @(negedge clk);
    tReset();
    tEightBit();
    tNineBitAndHold();
    tFilterData();
    tOwnAddr();
    tBroadcast();
    tNoMatch();
    tStopBit();
    tGlitch();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule